// File: doc/BRIEF.md
# Dual-Port Address-Match Busy Arbiter

This block sits beside a memory array that two independent ports share. Every clock it compares the two ports' enable and address inputs. When both ports are enabled on the same word, it names one port the owner of that word and drives an active-low busy flag to the other port. It also removes the other port's write strobe before it reaches the array, so two ports can never write the same word at once, and a read can never race a write there. The choice depends only on enable and address. Whether an access is a read or a write plays no part in it.

Ownership goes to the port whose enable and address were already settled in the previous cycle while the other port's request changed. When both requests change in the same cycle, or when both were already settled (for example on a return from slave mode), the left port wins. The owner keeps the word for as long as the match lasts. The busy flag drops once the addresses differ or either enable goes inactive.

A strap input selects the mode. With the strap high the block arbitrates. With the strap low it is a slave: the arbiter is held idle, both busy outputs stay high, and two external active-low busy inputs gate each port's writes directly. A slave array is placed next to a master so that the two together form a wider data word.

Top module: `dp_busy_arbiter`

## Requirements
- R1: With the strap high, both busy outputs stay high (inactive) while the two addresses differ or either port's enable is low.
- R2: When both enables are high and the addresses become equal, the port whose enable and address did not change in the previous cycle wins. The busy output of the other port goes low on the clock edge that samples the matching inputs.
- R3: The two busy outputs are never low in the same cycle.
- R4: When both requests change in the cycle where the match begins, or neither changes, the left port wins and the right busy output goes low. This also holds at the highest address.
- R5: The write request inputs have no effect on which port wins.
- R6: A port's gated write output is low in every cycle where that port is blocked. In master mode a port is blocked while its busy output is low. In slave mode it is blocked while its external busy input is low. Otherwise the gated write output equals the write request.
- R7: Once a port has won, it stays the winner while the match continues, whatever the two ports do with their write requests.
- R8: The busy output returns high on the first clock edge that samples a mismatch of the addresses or a low enable on either port, including the winner's.
- R9: With the strap low, both busy outputs are high regardless of any address match. Writes are inhibited only by the matching external busy input: left input to left port, right input to right port.
- R10: While the asynchronous active-low reset is asserted, both busy outputs are high. This holds even if reset arrives in the middle of a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | Strap: 1 selects arbitration, 0 selects the slave write-inhibit path |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W | Right port word address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left external busy, active low, used in slave mode |
| r_busy_in_n | input | 1 | Right external busy, active low, used in slave mode |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| r_busy_n | output | 1 | Right busy flag, active low, registered |
| l_wr_gated | output | 1 | Left write strobe as passed to the array |
| r_wr_gated | output | 1 | Right write strobe as passed to the array |

## Verification
The bench builds the block with ADDR_W set to 4, so a handful of hand-picked addresses both collide and differ, and the all-ones top address is cheap to reach. That width lets one vector table walk through every ordering of arrival: left first, right first, both in the same cycle, and both already settled. The same table covers winner hold during a match, release when the match or either enable ends, and the switch into and out of slave mode. Directed steps after the table cover the reset value and a reset that arrives during a live match.

// File: rtl/dpba_pkg.sv
package dpba_pkg;

  localparam int NPORTS = 2;
  localparam int LEFT   = 0;
  localparam int RIGHT  = 1;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'b00,
    WIN_LEFT  = 2'b01,
    WIN_RIGHT = 2'b10
  } win_t;

endpackage

// File: rtl/dpba_req_track.sv
module dpba_req_track #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);

  logic              prev_en_q, prev_en_d;
  logic [ADDR_W-1:0] prev_addr_q, prev_addr_d;

  // The previous request is captured every cycle; the clock enable is always on.
  always_comb begin
    prev_en_d   = en;
    prev_addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_en_q   <= prev_en_d;
      prev_addr_q <= prev_addr_d;
    end
  end

  // A request counts as settled when it did not change since the last edge.
  always_comb begin
    settled = (en == prev_en_q) && (addr == prev_addr_q);
  end

endmodule

// File: rtl/dpba_match.sv
module dpba_match #(
  parameter int ADDR_W = 15
) (
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              match
);

  logic both_on;
  logic same_word;

  always_comb begin
    both_on   = l_en & r_en;
    same_word = (l_addr == r_addr);
    match     = both_on & same_word;
  end

endmodule

// File: rtl/dpba_arb_fsm.sv
module dpba_arb_fsm
  import dpba_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              match,
  input  logic [NPORTS-1:0] settled,
  output win_t              win
);

  win_t win_q, win_d;
  win_t fresh_pick;

  // Ownership of a new match goes to the settled port; ties go left.
  always_comb begin
    if (settled[RIGHT] && !settled[LEFT]) fresh_pick = WIN_RIGHT;
    else                                  fresh_pick = WIN_LEFT;
  end

  always_comb begin
    win_d = win_q;
    if (!master_sel || !match) begin
      win_d = WIN_NONE;
    end else if (win_q == WIN_NONE) begin
      win_d = fresh_pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= WIN_NONE;
    else        win_q <= win_d;
  end

  assign win = win_q;

  // R7: the owner is kept while the match persists in master mode
  assert_winner_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != WIN_NONE && match && master_sel) |=> (win_q == $past(win_q)));

  // R8: a mismatch or dropped enable releases ownership on the next edge
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!match) |=> (win_q == WIN_NONE));

  // R9: slave mode keeps the arbiter idle
  assert_slave_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel) |=> (win_q == WIN_NONE));

  // R4: simultaneous or already-settled arrivals go to the left port
  assert_tie_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_NONE && match && master_sel && (settled[LEFT] == settled[RIGHT]))
    |=> (win_q == WIN_LEFT));

  // R2: the port settled before the other wins a new match
  assert_first_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_NONE && match && master_sel && settled[RIGHT] && !settled[LEFT])
    |=> (win_q == WIN_RIGHT));

endmodule

// File: rtl/dpba_wr_gate.sv
module dpba_wr_gate (
  input  logic master_sel,
  input  logic arb_lose,
  input  logic busy_in_n,
  input  logic wr_req,
  output logic wr_out
);

  logic inhibit;

  always_comb begin
    if (master_sel) inhibit = arb_lose;
    else            inhibit = ~busy_in_n;
    wr_out = wr_req & ~inhibit;
  end

endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_gated,
  output logic              r_wr_gated
);

  logic [NPORTS-1:0] p_en;
  logic [ADDR_W-1:0] p_addr [NPORTS];
  logic [NPORTS-1:0] p_wr;
  logic [NPORTS-1:0] p_busy_in_n;
  logic [NPORTS-1:0] p_settled;
  logic [NPORTS-1:0] p_lose;
  logic [NPORTS-1:0] p_wr_out;
  logic              match;
  win_t              win;

  always_comb begin
    p_en[LEFT]          = l_en;
    p_en[RIGHT]         = r_en;
    p_addr[LEFT]        = l_addr;
    p_addr[RIGHT]       = r_addr;
    p_wr[LEFT]          = l_wr;
    p_wr[RIGHT]         = r_wr;
    p_busy_in_n[LEFT]   = l_busy_in_n;
    p_busy_in_n[RIGHT]  = r_busy_in_n;
  end

  dpba_match #(.ADDR_W(ADDR_W)) u_match (
    .l_en   (l_en),
    .l_addr (l_addr),
    .r_en   (r_en),
    .r_addr (r_addr),
    .match  (match)
  );

  dpba_arb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .match      (match),
    .settled    (p_settled),
    .win        (win)
  );

  always_comb begin
    p_lose[LEFT]  = master_sel & (win == WIN_RIGHT);
    p_lose[RIGHT] = master_sel & (win == WIN_LEFT);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpba_req_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (p_en[p]),
      .addr    (p_addr[p]),
      .settled (p_settled[p])
    );

    dpba_wr_gate u_gate (
      .master_sel (master_sel),
      .arb_lose   (p_lose[p]),
      .busy_in_n  (p_busy_in_n[p]),
      .wr_req     (p_wr[p]),
      .wr_out     (p_wr_out[p])
    );
  end

  assign l_busy_n   = ~p_lose[LEFT];
  assign r_busy_n   = ~p_lose[RIGHT];
  assign l_wr_gated = p_wr_out[LEFT];
  assign r_wr_gated = p_wr_out[RIGHT];

  // R3: never both busy
  assert_busy_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  // R6: a busy port never passes a write to the array
  assert_left_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n) |-> (!l_wr_gated));
  assert_right_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n) |-> (!r_wr_gated));

  // R1: no match seen at an edge leaves both flags high afterwards
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_en && r_en && l_addr == r_addr)) |=> (l_busy_n && r_busy_n));

  // R9: slave mode drives no busy flag
  assert_slave_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel) |-> (l_busy_n && r_busy_n));

endmodule

// File: tb/sim_dp_busy_arbiter.sv
module sim_dp_busy_arbiter;

  localparam int AW    = 4;
  localparam int NVEC  = 17;
  localparam int VW    = 26;

  logic          clk;
  logic          rst_n;
  logic          master_sel;
  logic          l_en, r_en, l_wr, r_wr;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy_in_n, r_busy_in_n;
  logic          l_busy_n, r_busy_n, l_wr_gated, r_wr_gated;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  dp_busy_arbiter #(.ADDR_W(AW)) u0 (
    .clk (clk), .rst_n (rst_n), .master_sel (master_sel),
    .l_en (l_en), .l_addr (l_addr), .l_wr (l_wr),
    .r_en (r_en), .r_addr (r_addr), .r_wr (r_wr),
    .l_busy_in_n (l_busy_in_n), .r_busy_in_n (r_busy_in_n),
    .l_busy_n (l_busy_n), .r_busy_n (r_busy_n),
    .l_wr_gated (l_wr_gated), .r_wr_gated (r_wr_gated)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Row: strap, l_en, l_addr, l_wr, r_en, r_addr, r_wr, l_bin, r_bin,
  //      exp l_busy, exp r_busy, exp l_wrg, exp r_wrg, requirement id
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd3,  1'b0, 1'b0, 4'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
    {1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},
    {1'b1, 1'b1, 4'd3,  1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},
    {1'b1, 1'b1, 4'd5,  1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8},
    {1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
    {1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},
    {1'b1, 1'b1, 4'd3,  1'b1, 1'b0, 4'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8},
    {1'b1, 1'b1, 4'd9,  1'b1, 1'b1, 4'd9,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    {1'b1, 1'b1, 4'd9,  1'b0, 1'b1, 4'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
    {1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2},
    {1'b0, 1'b1, 4'd10, 1'b1, 1'b1, 4'd10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9},
    {1'b0, 1'b1, 4'd10, 1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9},
    {1'b0, 1'b1, 4'd10, 1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9},
    {1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    {1'b1, 1'b1, 4'd10, 1'b0, 1'b1, 4'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
    {1'b1, 1'b0, 4'd10, 1'b0, 1'b1, 4'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},
    {1'b1, 1'b1, 4'd15, 1'b1, 1'b1, 4'd15, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4}
  };

  function automatic string tag(input logic [3:0] id);
    case (id)
      4'd1:    tag = "R1";
      4'd2:    tag = "R2";
      4'd4:    tag = "R4";
      4'd5:    tag = "R5";
      4'd7:    tag = "R7";
      4'd8:    tag = "R8";
      4'd9:    tag = "R9";
      default: tag = "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    master_sel = 1'b1; l_en = 1'b0; r_en = 1'b0; l_wr = 1'b0; r_wr = 1'b0;
    l_addr = '0; r_addr = '0; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #1;
    // R10: flags high during reset
    check("R10", "busy pair in reset", {2'b00, l_busy_n, r_busy_n}, 4'b0011);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "busy pair after reset", {2'b00, l_busy_n, r_busy_n}, 4'b0011);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      {master_sel, l_en, l_addr, l_wr, r_en, r_addr, r_wr, l_busy_in_n, r_busy_in_n} = v[VW-1:8];
      @(posedge clk);
      @(negedge clk);
      check(tag(v[3:0]), $sformatf("row %0d busy", i),
            {2'b00, l_busy_n, r_busy_n}, {2'b00, v[7:6]});
      // R6: gated strobes follow the blocking rule
      check("R6", $sformatf("row %0d write gate", i),
            {2'b00, l_wr_gated, r_wr_gated}, {2'b00, v[5:4]});
      // R3: flags exclusive
      check("R3", $sformatf("row %0d exclusive", i),
            {3'b000, (!l_busy_n && !r_busy_n)}, 4'b0000);
    end

    // R5: only the write requests toggle during a match; owner unchanged
    master_sel = 1'b1; l_en = 1'b1; r_en = 1'b1; l_addr = 4'd6; r_addr = 4'd6;
    l_wr = 1'b0; r_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    l_wr = 1'b1; r_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5", "owner after write toggles", {2'b00, l_busy_n, r_busy_n}, 4'b0010);

    // R10: reset arriving during a live match clears the flag at once
    rst_n = 1'b0;
    #1;
    check("R10", "busy pair on reset in match", {2'b00, l_busy_n, r_busy_n}, 4'b0011);
    @(negedge clk);
    rst_n = 1'b1;
    idle_inputs();
    @(posedge clk); @(negedge clk);
    check("R1", "idle after reset release", {2'b00, l_busy_n, r_busy_n}, 4'b0011);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule